// File: doc/BRIEF.md
# Cascadable Dual 16-bit Counter

This block holds two 16-bit counter channels. The lower channel counts prescaled ticks of the system clock, or it runs as a 4x quadrature decoder on a pair of phase inputs and then counts up or down. The upper channel has the same options. It has one more clock-select code that makes it step on the lower channel's wrap events. With that code the two channels act as one 32-bit counter. A lower wrap from all-ones to zero adds one to the upper half. A lower wrap from zero to all-ones takes one from it. The lower counter can count down only in quadrature mode, so a wrap downward can only come from that mode.

Software sets up the block through a small write/read register port. Each channel has a control register that holds a 3-bit clock select and a phase-mode bit. A run register holds one start bit per channel. Both counters can be read and written. The usual sequence is:
1. Program the chaining code into the upper control register.
2. Set both start bits.

The full 32-bit value is also available on a dedicated output. The upper half steps on the same clock edge as the lower wrap, so the output never shows a half-updated carry.

Top module: `casc_counter_pair`

## Requirements
- R1: After reset both counters, both control registers and the run register read as zero.
- R2: Clock-select codes 3'b000, 3'b001, 3'b010 and 3'b011 count every clock, every 4th, every 16th and every 64th clock. The prescaler runs freely from reset, so a run of 256 clocks adds exactly 256, 64, 16 or 4.
- R3: Codes 3'b100 to 3'b110 never count. Code 3'b111 never counts on the lower channel.
- R4: When the upper clock select is 3'b111, its phase bit is clear and both channels run, a lower wrap from 16'hFFFF to 16'h0000 adds one to the upper counter on the same clock edge. The 32-bit output therefore advances by exactly one per lower count.
- R5: Under the same cascade setup, a lower wrap from 16'h0000 to 16'hFFFF takes one from the upper counter on the same clock edge. This can only happen when the lower channel is in phase mode and counting down.
- R6: Setting the upper phase bit (control bit 3) overrides its clock select. The upper counter then ignores lower wraps and follows only its own phase inputs.
- R7: A channel whose start bit is clear holds its value. Run bit 0 starts the lower channel and run bit 1 starts the upper one. With the lower channel stopped, no wrap reaches the upper counter. With the upper channel stopped, the upper counter ignores lower wraps.
- R8: In phase mode the state {A,B}, sampled through a two-stage synchroniser, counts up on the sequence 00, 01, 11, 10, 00 and down on the reverse. A change of both bits at once is ignored, and the new state becomes the reference for the next step.
- R9: A write to a counter register in the same cycle as a count event wins. The written value is loaded, and a lower wrap that this write suppresses does not reach the upper counter.
- R10: Register addresses: 0 lower control, 1 upper control, 2 run, 3 lower count, 4 upper count. Control bits are [2:0] clock select and [3] phase mode. Other addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Combinational read data |
| lo_pha | input | 1 | Lower channel phase A |
| lo_phb | input | 1 | Lower channel phase B |
| hi_pha | input | 1 | Upper channel phase A |
| hi_phb | input | 1 | Upper channel phase B |
| cnt32 | output | 32 | Upper and lower counters concatenated |

## Verification
The assertions assume the phase inputs start at 00 after reset. They also assume each phase state is held long enough to pass the synchroniser; otherwise a fast change could look like an invalid jump. The stimulus meets both conditions: it leaves the phase pins low through reset and holds every quadrature state for four clocks. Random quadrature walks around the lower counter's zero point exercise both carry and borrow, including deliberate double-bit jumps. Directed cases pin down wrap edges, write collisions and start-bit gating.

// File: rtl/casc_pkg.sv
// Shared constants for the cascadable counter pair: register addresses,
// clock-select codes and control field positions.
package casc_pkg;
    localparam int CNT_W     = 16;
    localparam int ADDR_W    = 3;
    localparam int CS_W      = 3;
    localparam int CTL_W     = CS_W + 1;
    localparam int PHASE_BIT = CS_W;

    localparam logic [ADDR_W-1:0] A_CTL_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTL_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_RUN    = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd4;

    localparam logic [CS_W-1:0] CS_CHAIN = 3'b111;
endpackage

// File: rtl/casc_prescaler.sv
// Free-running prescaler. Output bit i pulses once every (2**SHIFT)**i clocks.
// Bit 0 is high on every clock. Assumes it is never stopped after reset.
module casc_prescaler #(
    parameter int STAGES = 4,
    parameter int SHIFT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [STAGES-1:0] tick
);
    localparam int PW = SHIFT * (STAGES - 1);

    logic [PW-1:0] div_q;

    // Advance the shared divider every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    assign tick[0] = 1'b1;
    for (genvar i = 1; i < STAGES; i++) begin : g_tick
        // Stage i fires when its low i*SHIFT divider bits are all ones.
        assign tick[i] = &div_q[i*SHIFT-1:0];

        a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
            tick[i] |=> !tick[i]);
    end
endmodule

// File: rtl/casc_quad_dec.sv
// 4x quadrature decoder. Synchronises A and B through two flops, then compares
// the state with the last accepted one. Gray order 00,01,11,10 is forward.
// A change of both bits gives no step. Assumes the pins are 00 in reset.
module casc_quad_dec (
    input  logic clk,
    input  logic rst_n,
    input  logic pha,
    input  logic phb,
    output logic step_up,
    output logic step_dn
);
    logic [1:0] sync1_q, sync2_q, prev_q;

    function automatic logic [1:0] gray_next(input logic [1:0] s);
        case (s)
            2'b00:   gray_next = 2'b01;
            2'b01:   gray_next = 2'b11;
            2'b11:   gray_next = 2'b10;
            default: gray_next = 2'b00;
        endcase
    endfunction

    // Two-stage synchroniser, then remember the last decoded state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
            prev_q  <= '0;
        end else begin
            sync1_q <= {pha, phb};
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    // Classify the transition from prev_q to sync2_q.
    always_comb begin
        step_up = (sync2_q == gray_next(prev_q));
        step_dn = (prev_q == gray_next(sync2_q));
    end

    a_r8_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_up, step_dn}));
endmodule

// File: rtl/casc_channel.sv
// One counter channel. Phase mode takes priority over clock select. Codes
// 0..3 pick a prescaler tick. The chain code follows the neighbour's wrap
// events only when CHAIN_EN is set. A register write beats any count. Wrap
// outputs are combinational, so the neighbour steps on the same edge.
module casc_channel
    import casc_pkg::*;
#(
    parameter int    W        = CNT_W,
    parameter int    NTICK    = 4,
    parameter bit    CHAIN_EN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CS_W-1:0]  cs,
    input  logic             phase,
    input  logic             start,
    input  logic             wr,
    input  logic [W-1:0]     wr_val,
    input  logic [NTICK-1:0] tick,
    input  logic             q_up,
    input  logic             q_dn,
    input  logic             chain_up,
    input  logic             chain_dn,
    output logic [W-1:0]     cnt,
    output logic             wrap_up,
    output logic             wrap_dn
);
    logic up_ev, dn_ev, chain_sel, tick_sel;

    // Select the count source for this cycle.
    always_comb begin
        chain_sel = CHAIN_EN && (cs == CS_CHAIN);
        tick_sel  = (cs[CS_W-1] == 1'b0) && tick[cs[1:0]];
        if (phase) begin
            up_ev = q_up;
            dn_ev = q_dn;
        end else begin
            up_ev = tick_sel || (chain_sel && chain_up);
            dn_ev = chain_sel && chain_dn;
        end
        up_ev   = up_ev && start && !wr;
        dn_ev   = dn_ev && start && !wr;
        wrap_up = up_ev && (cnt == {W{1'b1}});
        wrap_dn = dn_ev && (cnt == '0);
    end

    // Load on write, else step up or down.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (wr)     cnt <= wr_val;
        else if (up_ev)  cnt <= cnt + 1'b1;
        else if (dn_ev)  cnt <= cnt - 1'b1;
    end

    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> cnt == $past(wr_val));
    a_r7_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !wr) |=> $stable(cnt));
endmodule

// File: rtl/casc_counter_pair.sv
// Two counter channels that can be chained into one 32-bit counter, with a
// simple register port. Channel 0 is the lower half and channel 1 the upper
// half; only channel 1 accepts the chain code. Reads are combinational.
module casc_counter_pair
    import casc_pkg::*;
#(
    parameter int PRE_STAGES = 4,
    parameter int PRE_SHIFT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              lo_pha,
    input  logic              lo_phb,
    input  logic              hi_pha,
    input  logic              hi_phb,
    output logic [2*CNT_W-1:0] cnt32
);
    localparam int NCH = 2;

    logic [CTL_W-1:0]      ctl_q [NCH];
    logic [NCH-1:0]        run_q;
    logic [PRE_STAGES-1:0] tick;
    logic [CNT_W-1:0]      cnt   [NCH];
    logic [NCH-1:0]        wrap_up, wrap_dn, q_up, q_dn, cnt_wr;
    logic [NCH-1:0]        pha, phb;

    assign pha = {hi_pha, lo_pha};
    assign phb = {hi_phb, lo_phb};

    casc_prescaler #(.STAGES(PRE_STAGES), .SHIFT(PRE_SHIFT)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    // Control and run registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q[0] <= '0;
            ctl_q[1] <= '0;
            run_q    <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CTL_LO) ctl_q[0] <= wr_data[CTL_W-1:0];
            if (wr_addr == A_CTL_HI) ctl_q[1] <= wr_data[CTL_W-1:0];
            if (wr_addr == A_RUN)    run_q    <= wr_data[NCH-1:0];
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign cnt_wr[i] = wr_en && (wr_addr == A_CNT_LO + ADDR_W'(i));

        casc_quad_dec u_qd (
            .clk(clk), .rst_n(rst_n), .pha(pha[i]), .phb(phb[i]),
            .step_up(q_up[i]), .step_dn(q_dn[i])
        );

        casc_channel #(.W(CNT_W), .NTICK(PRE_STAGES), .CHAIN_EN(i == 1)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .cs(ctl_q[i][CS_W-1:0]), .phase(ctl_q[i][PHASE_BIT]),
            .start(run_q[i]), .wr(cnt_wr[i]), .wr_val(wr_data),
            .tick(tick), .q_up(q_up[i]), .q_dn(q_dn[i]),
            .chain_up(wrap_up[0]), .chain_dn(wrap_dn[0]),
            .cnt(cnt[i]), .wrap_up(wrap_up[i]), .wrap_dn(wrap_dn[i])
        );
    end

    // Register read multiplexer.
    always_comb begin
        case (rd_addr)
            A_CTL_LO: rd_data = CNT_W'(ctl_q[0]);
            A_CTL_HI: rd_data = CNT_W'(ctl_q[1]);
            A_RUN:    rd_data = CNT_W'(run_q);
            A_CNT_LO: rd_data = cnt[0];
            A_CNT_HI: rd_data = cnt[1];
            default:  rd_data = '0;
        endcase
    end

    assign cnt32 = {cnt[1], cnt[0]};

    logic chained;
    assign chained = run_q[1] && !ctl_q[1][PHASE_BIT] && (ctl_q[1][CS_W-1:0] == CS_CHAIN);

    a_r4_carry_same_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (chained && wrap_up[0] && !cnt_wr[1]) |=> cnt[1] == $past(cnt[1]) + 1'b1);
    a_r5_borrow_same_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (chained && wrap_dn[0] && !cnt_wr[1]) |=> cnt[1] == $past(cnt[1]) - 1'b1);
    a_r6_phase_blocks_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[1][PHASE_BIT] && !q_up[1] && !q_dn[1] && !cnt_wr[1]) |=> $stable(cnt[1]));
endmodule

// File: tb/casc_counter_pair_test.sv
module casc_counter_pair_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        lo_pha = 0, lo_phb = 0, hi_pha = 0, hi_phb = 0;
    logic [31:0] cnt32;

    int checks = 0;
    int errors = 0;
    logic [1:0] qlo = 2'b00, qhi = 2'b00;

    casc_counter_pair uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .lo_pha(lo_pha), .lo_phb(lo_phb), .hi_pha(hi_pha), .hi_phb(hi_phb),
        .cnt32(cnt32)
    );

    always #5 clk = ~clk;

    function automatic logic [1:0] fwd(input logic [1:0] s);
        case (s)
            2'b00: fwd = 2'b01;
            2'b01: fwd = 2'b11;
            2'b11: fwd = 2'b10;
            default: fwd = 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] bwd(input logic [1:0] s);
        case (s)
            2'b01: bwd = 2'b00;
            2'b11: bwd = 2'b01;
            2'b10: bwd = 2'b11;
            default: bwd = 2'b10;
        endcase
    endfunction

    function automatic logic [31:0] step_model(input logic [31:0] v,
                                               input logic [1:0] from, input logic [1:0] to);
        if (to == fwd(from))      step_model = v + 1;
        else if (from == fwd(to)) step_model = v - 1;
        else                      step_model = v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic qmove(input bit hi, input logic [1:0] s);
        if (hi) begin {hi_pha, hi_phb} = s; qhi = s; end
        else    begin {lo_pha, lo_phb} = s; qlo = s; end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v, v2;
        logic [31:0] exp32;
        logic [1:0] nx;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R10 reset state and read map
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1", {16'h0, v}, 32'h0);
        end

        // R2 divide ratios over 256 clocks
        for (int c = 0; c < 4; c++) begin
            wr(3'd3, 16'h0);
            wr(3'd0, 16'(c));
            wr(3'd2, 16'h1);
            repeat (255) @(negedge clk);
            wr(3'd2, 16'h0);
            rd(3'd3, v);
            chk("R2", {16'h0, v}, 32'(256 >> (2 * c)));
        end

        // R3 reserved and chain codes on the lower channel do not count
        for (int c = 4; c < 8; c++) begin
            wr(3'd3, 16'h0);
            wr(3'd0, 16'(c));
            wr(3'd2, 16'h1);
            repeat (100) @(negedge clk);
            wr(3'd2, 16'h0);
            rd(3'd3, v);
            chk("R3", {16'h0, v}, 32'h0);
        end

        // R10 control read-back (phase bit 3, select bits 2:0)
        wr(3'd1, 16'h000F);
        rd(3'd1, v);
        chk("R10", {16'h0, v}, 32'hF);

        // R4 carry on the same edge, cnt32 advances by one per clock
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0007);
        wr(3'd3, 16'hFFFE);
        wr(3'd4, 16'h0005);
        wr(3'd2, 16'h3);
        for (int k = 0; k < 5; k++) begin
            chk("R4", cnt32, 32'h0005FFFE + 32'(k));
            @(negedge clk);
        end
        wr(3'd2, 16'h0);

        // R9 write beats count, and suppressed wrap does not carry
        wr(3'd3, 16'hFFFF);
        wr(3'd4, 16'h0009);
        wr(3'd2, 16'h3);
        wr(3'd3, 16'h0100);
        chk("R9", cnt32, 32'h0009_0100);
        @(negedge clk);
        chk("R9", cnt32, 32'h0009_0101);
        wr(3'd2, 16'h0);

        // R7 only lower started: upper ignores wraps
        wr(3'd3, 16'hFFFE);
        wr(3'd4, 16'h0007);
        wr(3'd2, 16'h1);
        repeat (8) @(negedge clk);
        rd(3'd4, v);
        chk("R7", {16'h0, v}, 32'h7);
        // R7 only upper started: lower frozen
        wr(3'd2, 16'h2);
        rd(3'd3, v);
        repeat (8) @(negedge clk);
        rd(3'd3, v2);
        chk("R7", {16'h0, v2}, {16'h0, v});
        wr(3'd2, 16'h0);

        // R6 upper phase mode overrides chain code
        wr(3'd1, 16'h000F);
        wr(3'd3, 16'hFFF0);
        wr(3'd4, 16'h0044);
        wr(3'd2, 16'h3);
        repeat (40) @(negedge clk);
        rd(3'd4, v);
        chk("R6", {16'h0, v}, 32'h44);
        qmove(1'b1, fwd(qhi));
        rd(3'd4, v);
        chk("R6", {16'h0, v}, 32'h45);
        wr(3'd2, 16'h0);

        // R5 borrow from lower phase-mode down count
        wr(3'd0, 16'h0008);
        wr(3'd1, 16'h0007);
        wr(3'd3, 16'h0001);
        wr(3'd4, 16'h0020);
        wr(3'd2, 16'h3);
        qmove(1'b0, bwd(qlo));
        qmove(1'b0, bwd(qlo));
        chk("R5", cnt32, 32'h001F_FFFF);
        qmove(1'b0, fwd(qlo));
        chk("R4", cnt32, 32'h0020_0000);

        // R8 invalid jump ignored
        qmove(1'b0, qlo ^ 2'b11);
        chk("R8", cnt32, 32'h0020_0000);

        // R8 / R5 / R4 random quadrature walk around zero
        wr(3'd3, 16'h0000);
        wr(3'd4, 16'h0100);
        exp32 = 32'h0100_0000;
        for (int n = 0; n < 300; n++) begin
            case ($urandom % 4)
                0: nx = fwd(qlo);
                1: nx = bwd(qlo);
                2: nx = qlo ^ 2'b11;
                default: nx = qlo;
            endcase
            exp32 = step_model(exp32, qlo, nx);
            qmove(1'b0, nx);
            chk("R8", cnt32, exp32);
        end
        wr(3'd2, 16'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule